// File: doc/BRIEF.md
# Serial (7,4) Cyclic Codec with Single-Error Correction

This block holds two independent serial paths built on the generator polynomial g(x) = x^3 + x + 1. The encode path takes four message bits one at a time and returns a systematic 7-bit codeword in parallel. The message sits in the upper four bits. The lower three bits are the remainder of x^3·m(x) divided by g(x), worked out by a feedback shift register as the bits arrive.

The decode path takes seven received bits one at a time and divides them through a three-stage syndrome register. It turns the syndrome into a one-hot error pattern, then returns the corrected word in parallel with an error flag. A nonzero syndrome always flips exactly one bit. The code is a perfect single-error-correcting code, so every received word maps to a valid codeword.

Each path has three serial inputs: a bit, a valid strobe and a start-of-word strobe. Each path gives a one-cycle valid pulse when a word is done. On both paths the bit sent first is the highest-degree coefficient, so it lands in bit 6 (decoder) or bit 3 of the message (encoder).

Top module: `cyc74_codec`

## Requirements
- R1: For message bits m3..m0, with m3 sent first, `enc_cw` = {m3,m2,m1,m0,p2,p1,p0}. Here p(x) = p2·x^2 + p1·x + p0 is the remainder of x^3·m(x) mod (x^3+x+1). Message 1001 gives codeword 1001110, and every codeword leaves remainder zero.
- R2: `enc_cw_valid` is high for exactly one cycle. That cycle starts at the clock edge that samples the fourth message bit.
- R3: On either path, a valid bit with the start strobe set begins a new word and drops any partly received word. A valid bit without the start strobe, arriving while no word is open, is ignored: it raises no valid pulse and does not change the next word.
- R4: The decoder syndrome is the remainder of the received polynomial mod (x^3+x+1), where the first bit received is the x^6 coefficient. The syndrome is rebuilt from zero for each word.
- R5: When the syndrome is zero, `dec_err` is 0 and `dec_word` equals the received word.
- R6: For a single error at bit k (bit 6 is the first bit received), the syndrome {s2,s1,s0} is x^k mod g. For k = 0..6 this is 001, 010, 100, 011, 110, 111, 101. The decoder flips exactly that bit and sets `dec_err`.
- R7: `dec_word_valid` is high for exactly one cycle. That cycle starts at the clock edge that samples the seventh received bit. `dec_word` and `dec_err` hold until the next word is done.
- R8: A synchronous reset clears both valid outputs, `enc_cw`, `dec_word` and `dec_err`.
- R9: For a word with two bit errors, `dec_err` is 1 and `dec_word` is the codeword one bit away from the received word. This is a miscorrection.
- R10: Idle cycles with the valid strobe low, inserted between bits of a word, do not change the result on either path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_valid | input | 1 | Encoder serial bit strobe |
| enc_sow | input | 1 | Encoder start-of-word, sampled with `enc_valid` |
| enc_bit | input | 1 | Encoder message bit |
| enc_cw | output | N | Encoded codeword |
| enc_cw_valid | output | 1 | One-cycle pulse when `enc_cw` is new |
| dec_valid | input | 1 | Decoder serial bit strobe |
| dec_sow | input | 1 | Decoder start-of-word, sampled with `dec_valid` |
| dec_bit | input | 1 | Received bit |
| dec_word | output | N | Corrected codeword |
| dec_err | output | 1 | Nonzero syndrome seen for this word |
| dec_word_valid | output | 1 | One-cycle pulse when `dec_word` is new |

## Verification
The checker keeps its own record of the last four encoder bits and the last seven decoder bits. It assumes those bits are exactly the word just finished, which holds because stray bits only come before a start strobe. It also assumes at least two cycles pass between two finished words. The stimulus meets both conditions: every word is sent in full, with its start strobe, and the random gaps only add idle cycles. Restarted and stray fragments are always followed by a complete word.

// File: rtl/cyc_pkg.sv
package cyc_pkg;

  // Remainder of x^k modulo g(x) = x^r + taps, as an r-bit value (bit i = coefficient of x^i).
  function automatic int unsigned pow_mod(input int k, input int r, input int unsigned taps);
    int unsigned v;
    int unsigned msk;
    v   = 1;
    msk = (32'd1 << r) - 32'd1;
    for (int j = 0; j < k; j++) begin
      logic carry;
      carry = v[r-1];
      v = (v << 1) & msk;
      if (carry) v = v ^ taps;
    end
    return v & msk;
  endfunction

  // Remainder of an n-bit word (bit i = coefficient of x^i) modulo g(x).
  function automatic int unsigned word_rem(input int unsigned w, input int n, input int r,
                                           input int unsigned taps);
    int unsigned acc;
    acc = 0;
    for (int i = 0; i < n; i++) begin
      if (w[i]) acc = acc ^ pow_mod(i, r, taps);
    end
    return acc;
  endfunction

endpackage

// File: rtl/cyc_lfsr_step.sv
// One combinational step of a division register for g(x) = x^R + taps.
// PREMUL=1: input is premultiplied by x^R (encoder form).
// PREMUL=0: plain division of the incoming stream (syndrome form).
module cyc_lfsr_step #(
  parameter int          R      = 3,
  parameter int unsigned GTAPS  = 3,
  parameter bit          PREMUL = 1'b1
) (
  input  logic [R-1:0] cur,
  input  logic         din,
  output logic [R-1:0] nxt
);
  localparam logic [R-1:0] TAPV = R'(GTAPS);

  logic top_xor;
  logic fbk;

  assign top_xor = din ^ cur[R-1];

  if (PREMUL) begin : g_pre
    assign fbk = top_xor;
  end else begin : g_div
    assign fbk = cur[R-1];
  end

  assign nxt[0] = top_xor;

  for (genvar i = 1; i < R; i++) begin : g_stage
    if (TAPV[i]) begin : g_tap
      assign nxt[i] = cur[i-1] ^ fbk;
    end else begin : g_pass
      assign nxt[i] = cur[i-1];
    end
  end
endmodule

// File: rtl/cyc_encoder.sv
module cyc_encoder #(
  parameter int          N     = 7,
  parameter int          K     = 4,
  parameter int unsigned GTAPS = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         in_sow,
  input  logic         in_bit,
  output logic [N-1:0] cw,
  output logic         cw_valid
);
  localparam int R  = N - K;
  localparam int CW = $clog2(K + 1);

  logic [R-1:0]  par_q, par_base, par_nx;
  logic [K-1:0]  msg_q, msg_base, msg_nx;
  logic [CW-1:0] cnt_q, cnt_base;
  logic          open_q;
  logic          accept, last;

  assign accept   = in_valid && (in_sow || open_q);
  assign par_base = in_sow ? '0 : par_q;
  assign msg_base = in_sow ? '0 : msg_q;
  assign cnt_base = in_sow ? '0 : cnt_q;
  assign last     = accept && (cnt_base == CW'(K - 1));

  if (K > 1) begin : g_msg_wide
    assign msg_nx = {msg_base[K-2:0], in_bit};
  end else begin : g_msg_one
    assign msg_nx = in_bit;
  end

  cyc_lfsr_step #(.R(R), .GTAPS(GTAPS), .PREMUL(1'b1)) u_step (
    .cur (par_base),
    .din (in_bit),
    .nxt (par_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      par_q    <= '0;
      msg_q    <= '0;
      cnt_q    <= '0;
      open_q   <= 1'b0;
      cw       <= '0;
      cw_valid <= 1'b0;
    end else begin
      cw_valid <= 1'b0;
      if (accept) begin
        par_q <= par_nx;
        msg_q <= msg_nx;
        if (last) begin
          open_q   <= 1'b0;
          cnt_q    <= '0;
          cw       <= {msg_nx, par_nx};
          cw_valid <= 1'b1;
        end else begin
          open_q <= 1'b1;
          cnt_q  <= cnt_base + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/cyc_syndrome.sv
module cyc_syndrome #(
  parameter int          N     = 7,
  parameter int          R     = 3,
  parameter int unsigned GTAPS = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         in_sow,
  input  logic         in_bit,
  output logic         done,
  output logic [R-1:0] syn_nx,
  output logic [N-1:0] word_nx
);
  localparam int CW = $clog2(N + 1);

  logic [R-1:0]  syn_q, syn_base;
  logic [N-1:0]  word_q, word_base;
  logic [CW-1:0] cnt_q, cnt_base;
  logic          open_q;
  logic          accept;

  assign accept    = in_valid && (in_sow || open_q);
  assign syn_base  = in_sow ? '0 : syn_q;
  assign word_base = in_sow ? '0 : word_q;
  assign cnt_base  = in_sow ? '0 : cnt_q;
  assign done      = accept && (cnt_base == CW'(N - 1));
  assign word_nx   = {word_base[N-2:0], in_bit};

  cyc_lfsr_step #(.R(R), .GTAPS(GTAPS), .PREMUL(1'b0)) u_step (
    .cur (syn_base),
    .din (in_bit),
    .nxt (syn_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      syn_q  <= '0;
      word_q <= '0;
      cnt_q  <= '0;
      open_q <= 1'b0;
    end else if (accept) begin
      syn_q  <= syn_nx;
      word_q <= word_nx;
      if (done) begin
        open_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        open_q <= 1'b1;
        cnt_q  <= cnt_base + CW'(1);
      end
    end
  end
endmodule

// File: rtl/cyc_corrector.sv
module cyc_corrector #(
  parameter int          N     = 7,
  parameter int          R     = 3,
  parameter int unsigned GTAPS = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         done,
  input  logic [R-1:0] syn,
  input  logic [N-1:0] word,
  output logic [N-1:0] out_word,
  output logic         out_err,
  output logic         out_valid
);
  logic [N-1:0] pat;

  // Error at bit k leaves syndrome x^k mod g; match each position against its signature.
  for (genvar k = 0; k < N; k++) begin : g_sig
    localparam int unsigned SIGK = cyc_pkg::pow_mod(k, R, GTAPS);
    assign pat[k] = (syn == SIGK[R-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_word  <= '0;
      out_err   <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= done;
      if (done) begin
        out_word <= word ^ pat;
        out_err  <= |syn;
      end
    end
  end
endmodule

// File: rtl/cyc74_codec.sv
module cyc74_codec #(
  parameter int          N     = 7,
  parameter int          K     = 4,
  parameter int unsigned GTAPS = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enc_valid,
  input  logic         enc_sow,
  input  logic         enc_bit,
  output logic [N-1:0] enc_cw,
  output logic         enc_cw_valid,
  input  logic         dec_valid,
  input  logic         dec_sow,
  input  logic         dec_bit,
  output logic [N-1:0] dec_word,
  output logic         dec_err,
  output logic         dec_word_valid
);
  localparam int R = N - K;

  logic         syn_done;
  logic [R-1:0] syn_val;
  logic [N-1:0] rx_word;

  cyc_encoder #(.N(N), .K(K), .GTAPS(GTAPS)) u_enc (
    .clk      (clk),
    .rst      (rst),
    .in_valid (enc_valid),
    .in_sow   (enc_sow),
    .in_bit   (enc_bit),
    .cw       (enc_cw),
    .cw_valid (enc_cw_valid)
  );

  cyc_syndrome #(.N(N), .R(R), .GTAPS(GTAPS)) u_syn (
    .clk      (clk),
    .rst      (rst),
    .in_valid (dec_valid),
    .in_sow   (dec_sow),
    .in_bit   (dec_bit),
    .done     (syn_done),
    .syn_nx   (syn_val),
    .word_nx  (rx_word)
  );

  cyc_corrector #(.N(N), .R(R), .GTAPS(GTAPS)) u_cor (
    .clk       (clk),
    .rst       (rst),
    .done      (syn_done),
    .syn       (syn_val),
    .word      (rx_word),
    .out_word  (dec_word),
    .out_err   (dec_err),
    .out_valid (dec_word_valid)
  );
endmodule

// File: rtl/cyc74_codec_chk.sv
module cyc74_codec_chk #(
  parameter int          N     = 7,
  parameter int          K     = 4,
  parameter int unsigned GTAPS = 3
) (
  input logic         clk,
  input logic         rst,
  input logic         enc_valid,
  input logic         enc_bit,
  input logic [N-1:0] enc_cw,
  input logic         enc_cw_valid,
  input logic         dec_valid,
  input logic         dec_bit,
  input logic [N-1:0] dec_word,
  input logic         dec_err,
  input logic         dec_word_valid
);
  localparam int R = N - K;

  logic [K-1:0] enc_sh;
  logic [N-1:0] dec_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      enc_sh <= '0;
      dec_sh <= '0;
    end else begin
      if (enc_valid) enc_sh <= {enc_sh[K-2:0], enc_bit};
      if (dec_valid) dec_sh <= {dec_sh[N-2:0], dec_bit};
    end
  end

  AST_ENC_IS_CODEWORD: assert property (@(posedge clk) disable iff (rst)
    enc_cw_valid |-> cyc_pkg::word_rem(32'(enc_cw), N, R, GTAPS) == 0); // R1
  AST_ENC_SYSTEMATIC: assert property (@(posedge clk) disable iff (rst)
    enc_cw_valid |-> enc_cw[N-1:R] == enc_sh); // R1
  AST_ENC_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    enc_cw_valid |=> !enc_cw_valid); // R2
  AST_ENC_AFTER_BIT: assert property (@(posedge clk) disable iff (rst)
    $rose(enc_cw_valid) |-> $past(enc_valid)); // R2
  AST_DEC_FLAG_SYN: assert property (@(posedge clk) disable iff (rst)
    dec_word_valid |-> dec_err == (cyc_pkg::word_rem(32'(dec_sh), N, R, GTAPS) != 0)); // R4
  AST_DEC_CLEAN_PASS: assert property (@(posedge clk) disable iff (rst)
    (dec_word_valid && !dec_err) |-> dec_word == dec_sh); // R5
  AST_DEC_ONE_FLIP: assert property (@(posedge clk) disable iff (rst)
    (dec_word_valid && dec_err) |-> $countones(dec_word ^ dec_sh) == 1); // R6
  AST_DEC_IS_CODEWORD: assert property (@(posedge clk) disable iff (rst)
    dec_word_valid |-> cyc_pkg::word_rem(32'(dec_word), N, R, GTAPS) == 0); // R9
  AST_DEC_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    dec_word_valid |=> !dec_word_valid); // R7
  AST_DEC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !dec_word_valid |-> $stable(dec_word) && $stable(dec_err)); // R7
endmodule

bind cyc74_codec cyc74_codec_chk #(.N(N), .K(K), .GTAPS(GTAPS)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .enc_valid      (enc_valid),
  .enc_bit        (enc_bit),
  .enc_cw         (enc_cw),
  .enc_cw_valid   (enc_cw_valid),
  .dec_valid      (dec_valid),
  .dec_bit        (dec_bit),
  .dec_word       (dec_word),
  .dec_err        (dec_err),
  .dec_word_valid (dec_word_valid)
);

// File: tb/tb_cyc74_codec.sv
module tb_cyc74_codec;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enc_valid = 1'b0, enc_sow = 1'b0, enc_bit = 1'b0;
  logic       dec_valid = 1'b0, dec_sow = 1'b0, dec_bit = 1'b0;
  logic [6:0] enc_cw, dec_word;
  logic       enc_cw_valid, dec_err, dec_word_valid;

  int n_checks = 0;
  int n_errors = 0;

  always #5 clk = ~clk;

  cyc74_codec dut (
    .clk(clk), .rst(rst),
    .enc_valid(enc_valid), .enc_sow(enc_sow), .enc_bit(enc_bit),
    .enc_cw(enc_cw), .enc_cw_valid(enc_cw_valid),
    .dec_valid(dec_valid), .dec_sow(dec_sow), .dec_bit(dec_bit),
    .dec_word(dec_word), .dec_err(dec_err), .dec_word_valid(dec_word_valid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Long division by x^3+x+1 (1011), bit 6 = x^6.
  function automatic logic [2:0] ref_rem(input logic [6:0] w);
    logic [6:0] t;
    t = w;
    for (int d = 6; d >= 3; d--) if (t[d]) t = t ^ (7'b1011 << (d - 3));
    return t[2:0];
  endfunction

  function automatic logic [6:0] ref_encode(input logic [3:0] m);
    return {m, ref_rem({m, 3'b000})};
  endfunction

  function automatic logic [6:0] ref_correct(input logic [6:0] w);
    logic [6:0] r;
    r = w;
    if (ref_rem(w) != 3'b000)
      for (int k = 0; k < 7; k++) if (ref_rem(w ^ (7'b1 << k)) == 3'b000) r = w ^ (7'b1 << k);
    return r;
  endfunction

  task automatic enc_send(input logic [3:0] m, input int gapmax, input string tag);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      enc_valid = 1'b1; enc_sow = (i == 0); enc_bit = m[3-i];
      if (i < 3) repeat ($urandom_range(0, gapmax)) begin
        @(negedge clk); enc_valid = 1'b0; enc_sow = 1'b0;
      end
    end
    @(negedge clk);
    enc_valid = 1'b0; enc_sow = 1'b0;
    check({tag, " valid"}, 32'(enc_cw_valid), 32'd1);
    check({tag, " codeword"}, 32'(enc_cw), 32'(ref_encode(m)));
    @(negedge clk);
    check({tag, " R2 pulse ends"}, 32'(enc_cw_valid), 32'd0);
  endtask

  task automatic dec_send(input logic [6:0] w, input int gapmax, input string tag);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      dec_valid = 1'b1; dec_sow = (i == 0); dec_bit = w[6-i];
      if (i < 6) repeat ($urandom_range(0, gapmax)) begin
        @(negedge clk); dec_valid = 1'b0; dec_sow = 1'b0;
      end
    end
    @(negedge clk);
    dec_valid = 1'b0; dec_sow = 1'b0;
    check({tag, " valid"}, 32'(dec_word_valid), 32'd1);
    check({tag, " word"}, 32'(dec_word), 32'(ref_correct(w)));
    check({tag, " err"}, 32'(dec_err), 32'(ref_rem(w) != 3'b000));
    @(negedge clk);
    check({tag, " R7 pulse ends"}, 32'(dec_word_valid), 32'd0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [6:0] cw;
    void'($urandom(32'h0C7C_1E55));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    check("R8 enc_cw_valid", 32'(enc_cw_valid), 0);
    check("R8 dec_word_valid", 32'(dec_word_valid), 0);
    check("R8 enc_cw", 32'(enc_cw), 0);
    check("R8 dec_word", 32'(dec_word), 0);
    check("R8 dec_err", 32'(dec_err), 0);

    // R1 directed example and all messages, back to back
    enc_send(4'b1001, 0, "R1 msg1001");
    check("R1 1001 -> 1001110", 32'(enc_cw), 32'h4E);
    for (int m = 0; m < 16; m++) enc_send(4'(m), 0, "R1 R2 all msgs");
    // R10 gaps on encoder
    for (int i = 0; i < 40; i++) enc_send(4'($urandom_range(0, 15)), 3, "R10 enc gaps");

    // R3 encoder: stray bits while idle, then restart mid-word
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); enc_valid = 1'b1; enc_sow = 1'b0; enc_bit = 1'b1;
    end
    @(negedge clk); enc_valid = 1'b0;
    check("R3 enc stray no valid", 32'(enc_cw_valid), 0);
    @(negedge clk); enc_valid = 1'b1; enc_sow = 1'b1; enc_bit = 1'b1;
    @(negedge clk); enc_sow = 1'b0; enc_bit = 1'b1;
    @(negedge clk); enc_valid = 1'b0;
    check("R3 enc partial no valid", 32'(enc_cw_valid), 0);
    enc_send(4'b0010, 0, "R3 enc restart");

    // R4 R5 decoder on clean codewords
    dec_send(7'b1001110, 0, "R5 clean 1001110");
    for (int m = 0; m < 16; m++) dec_send(ref_encode(4'(m)), 0, "R4 R5 clean");

    // R6 single error at every position
    for (int k = 0; k < 7; k++) begin
      cw = ref_encode(4'($urandom_range(0, 15)));
      dec_send(cw ^ (7'b1 << k), 1, "R6 single");
      check("R6 restored", 32'(dec_word), 32'(cw));
    end

    // R9 double errors: miscorrected to a neighbour codeword
    for (int i = 0; i < 12; i++) begin
      int a, b;
      a = $urandom_range(0, 6);
      b = (a + $urandom_range(1, 6)) % 7;
      cw = ref_encode(4'($urandom_range(0, 15)));
      dec_send(cw ^ (7'b1 << a) ^ (7'b1 << b), 0, "R9 double");
      check("R9 err set", 32'(dec_err), 1);
      check("R9 is codeword", 32'(ref_rem(dec_word)), 0);
    end

    // R3 decoder: strays then partial then full word
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); dec_valid = 1'b1; dec_sow = 1'b0; dec_bit = 1'b1;
    end
    @(negedge clk); dec_valid = 1'b0;
    check("R3 dec stray no valid", 32'(dec_word_valid), 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); dec_valid = 1'b1; dec_sow = (i == 0); dec_bit = 1'b1;
    end
    @(negedge clk); dec_valid = 1'b0;
    check("R3 dec partial no valid", 32'(dec_word_valid), 0);
    dec_send(7'b0001011, 0, "R3 dec restart");

    // R10 random received words with gaps, plus encoder loopback
    for (int i = 0; i < 150; i++) dec_send(7'($urandom_range(0, 127)), 3, "R10 dec gaps");
    for (int i = 0; i < 20; i++) begin
      enc_send(4'($urandom_range(0, 15)), 2, "R1 loop enc");
      cw = enc_cw;
      dec_send(cw, 2, "R5 loop dec");
    end

    finish_run();
  end
endmodule